// File: doc/BRIEF.md
# Flash Bus Front End with Command Latch

This block sits between the asynchronous, active-low control pins of a byte-wide flash memory model and its internal logic, which runs on a faster system clock. It works out the bus cycle from the chip-select, output-enable and write-enable pins. For a read cycle it supplies data and a drive enable for the data pad. In every other cycle the pad is released.

For a write cycle the block captures the address when write-enable falls and the data when it rises. It then hands both to a downstream command state machine as a single-cycle strobe. A write never touches the array directly.

The block also keeps a busy flag for program and erase operations. Downstream logic starts the flag, and a loadable cycle counter ends it. While the flag is set, reads return a status byte instead of array data. Deselecting the chip has no effect on a running operation.

Top module: `flash_bus_front`

## Requirements
- R1: After reset `busy` is 0, `cmd_valid` is 0 and `dq_oe` is 0.
- R2: With `cs_n`=0, `oe_n`=0 and `we_n`=1 while not busy, `dq_oe` is 1 and `dq_out` equals `array_q`.
- R3: Whenever `oe_n` is 1, `dq_oe` is 0.
- R4: Whenever `cs_n` is 1, `dq_oe` is 0, even when `oe_n` is 0.
- R5: A write is accepted when, at the synchronised falling edge of `we_n`, `cs_n` is 0 and `oe_n` is 1. An accepted write raises `cmd_valid` for exactly one clock after the synchronised rising edge of `we_n`. That strobe carries the `addr` value sampled at the falling edge and the `dq_in` value sampled at the rising edge.
- R6: If `oe_n` is 0 or `cs_n` is 1 when `we_n` falls, no `cmd_valid` pulse follows that pulse of `we_n`.
- R7: A one-cycle `op_start` while idle sets `busy` on the next clock. `busy` stays 1 for exactly `op_cycles` clocks when `op_cycles` is 1 or more, and for one clock when it is 0.
- R8: Raising `cs_n` while `busy` is 1 does not shorten the busy period.
- R9: A read cycle while `busy` is 1 drives the status byte 8'h80 on `dq_out` instead of `array_q`.
- R10: While `we_n` is 0, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Bus address |
| dq_in | input | DW | Data arriving from the pad |
| array_q | input | DW | Array read data for `addr` |
| op_start | input | 1 | One-cycle start of a program or erase |
| op_cycles | input | CW | Length of the busy period in clocks |
| dq_out | output | DW | Data to the pad |
| dq_oe | output | 1 | Pad drive enable; 0 means high impedance |
| cmd_valid | output | 1 | One-cycle strobe for a latched command |
| cmd_addr | output | AW | Latched command address |
| cmd_data | output | DW | Latched command data |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench changes `addr` after the falling edge of write-enable and changes the data before the rising edge. A design that latches both on one edge would therefore report the wrong address or the wrong data.

The bench also starts writes with output-enable low or chip-select high. A design that skips the acceptance check would emit a spurious strobe.

Chip-select is deselected partway through a busy period. A design that ties busy to selection would finish early.

The pad enable is checked in standby, with output disabled and during write-enable, and the status byte is checked during busy. These checks catch bus contention and reads that return array data while an operation is running.

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [DW-1:0] STATUS = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  input  logic [DW-1:0] array_q,
  input  logic          op_start,
  input  logic [CW-1:0] op_cycles,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          busy
);
  logic [2:0]    we_p, cs_p, oe_p;
  logic          armed;
  logic [AW-1:0] addr_hold;
  logic [CW-1:0] cnt;

  wire we_fall = !we_p[1] && we_p[2];
  wire we_rise = we_p[1] && !we_p[2];

  assign dq_oe  = !cs_n && !oe_n && we_n;
  assign dq_out = busy ? STATUS : array_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_p <= '1;
      cs_p <= '1;
      oe_p <= '1;
    end else begin
      we_p <= {we_p[1:0], we_n};
      cs_p <= {cs_p[1:0], cs_n};
      oe_p <= {oe_p[1:0], oe_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      addr_hold <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (we_fall) begin
        armed     <= !cs_p[1] && oe_p[1];
        addr_hold <= addr;
      end else if (we_rise) begin
        armed <= 1'b0;
        if (armed) begin
          cmd_valid <= 1'b1;
          cmd_addr  <= addr_hold;
          cmd_data  <= dq_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (op_start) begin
        busy <= 1'b1;
        cnt  <= (op_cycles == '0) ? CW'(1) : op_cycles;
      end
    end else if (cnt <= CW'(1)) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

module flash_bus_front_chk #(
  parameter int DW = 8,
  parameter logic [DW-1:0] STATUS = 8'h80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          op_start,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          cmd_valid,
  input logic          busy
);
  a_r3_oe_high_release: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dq_oe);
  a_r4_standby_release: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !dq_oe);
  a_r10_write_release:  assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !dq_oe);
  a_r5_single_strobe:   assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid);
  a_r7_busy_starts:     assert property (@(posedge clk) disable iff (!rst_n) (op_start && !busy) |=> busy);
  a_r9_status_byte:     assert property (@(posedge clk) disable iff (!rst_n) (dq_oe && busy) |-> dq_out == STATUS);
endmodule

bind flash_bus_front flash_bus_front_chk #(.DW(DW), .STATUS(STATUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .op_start(op_start), .dq_oe(dq_oe), .dq_out(dq_out),
  .cmd_valid(cmd_valid), .busy(busy)
);

// File: tb/sim_flash_bus_front.sv
module sim_flash_bus_front;
  localparam int AW = 17, DW = 8, CW = 16;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, oe_n = 1, we_n = 1, op_start = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, array_q = 8'h3C;
  logic [CW-1:0] op_cycles = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, cmd_valid, busy;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  flash_bus_front u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .array_q(array_q), .op_start(op_start),
    .op_cycles(op_cycles), .dq_out(dq_out), .dq_oe(dq_oe),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pulse(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                          input logic [DW-1:0] d1, input logic [DW-1:0] d2,
                          output int pulses, output logic [AW-1:0] ga,
                          output logic [DW-1:0] gd);
    pulses = 0; ga = '0; gd = '0;
    addr = a1; dq_in = d1;
    tick(1); we_n = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (cmd_valid) pulses++; end
    addr = a2; dq_in = d2;
    tick(2); we_n = 1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (cmd_valid) begin pulses++; ga = cmd_addr; gd = cmd_data; end
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 dq_oe", dq_oe, 0);
  endtask

  task automatic t_read;
    cs_n = 0; oe_n = 0; array_q = 8'hA5; tick(1);
    chk("R2 oe", dq_oe, 1); chk("R2 data", dq_out, 8'hA5);
    array_q = 8'h5A; tick(1);
    chk("R2 data2", dq_out, 8'h5A);
    oe_n = 1; tick(1); chk("R3 oe high", dq_oe, 0);
    cs_n = 1; oe_n = 0; tick(1); chk("R4 standby", dq_oe, 0);
    oe_n = 1; tick(1);
  endtask

  task automatic t_write;
    int p; logic [AW-1:0] a; logic [DW-1:0] d;
    cs_n = 0; oe_n = 1; tick(1);
    fork
      wr_pulse(17'h1ABCD, 17'h00011, 8'h11, 8'hC3, p, a, d);
      begin tick(3); checks++;
        if (dq_oe) begin errors++; $display("FAIL R10 actual=1 expected=0"); end end
    join
    chk("R5 pulses", p, 1); chk("R5 addr", a, 17'h1ABCD); chk("R5 data", d, 8'hC3);
    wr_pulse(17'h00555, 17'h00AAA, 8'h00, 8'h7E, p, a, d);
    chk("R5 pulses2", p, 1); chk("R5 addr2", a, 17'h00555); chk("R5 data2", d, 8'h7E);
    cs_n = 1; tick(1);
  endtask

  task automatic t_reject;
    int p; logic [AW-1:0] a; logic [DW-1:0] d;
    cs_n = 0; oe_n = 0; tick(4);
    wr_pulse(17'h00123, 17'h00123, 8'h44, 8'h44, p, a, d);
    chk("R6 oe low", p, 0);
    oe_n = 1; cs_n = 1; tick(4);
    wr_pulse(17'h00321, 17'h00321, 8'h55, 8'h55, p, a, d);
    chk("R6 cs high", p, 0);
  endtask

  task automatic t_busy(input int n, input int exp, input bit desel);
    int cnt = 0;
    op_cycles = CW'(n); op_start = 1; tick(1); op_start = 0;
    cs_n = 0; oe_n = 0; array_q = 8'h12;
    if (busy) begin
      chk("R9 status", dq_out, 8'h80);
      cnt++;
    end
    if (desel) begin cs_n = 1; oe_n = 1; end
    for (int i = 0; i < exp + 5; i++) begin tick(1); if (busy) cnt++; end
    chk(desel ? "R8 deselect length" : "R7 length", cnt, exp);
    cs_n = 0; oe_n = 0; tick(1);
    chk("R9 array after busy", dq_out, 8'h12);
    cs_n = 1; oe_n = 1; tick(1);
  endtask

  initial begin
    tick(3); t_reset(); rst_n = 1; tick(3);
    t_read();
    t_write();
    t_reject();
    t_busy(5, 5, 0);
    t_busy(0, 1, 0);
    t_busy(12, 12, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule